// File: doc/BRIEF.md
# AXI4 Burst DMA Command Master

This block converts a simple command (a byte start address plus a word count) into exactly one AXI4 burst on a 64-bit memory-mapped master port. Writes and reads each have their own engine, their own command handshake and their own valid/ready data stream. A write command moves the next words from the inbound stream into memory. A read command moves the fetched words out on the outbound stream.

Each command port uses its ready line for two jobs. It shows whether a new command can be taken, and it reports completion. Once a command is accepted, ready stays low until the burst has fully finished on the bus, then returns high. For a write, the burst has finished when the write response has been taken. For a read, it has finished when the last data beat has been delivered.

The caller must keep every command inside a 4 KiB region and must use 8-byte aligned addresses. Each direction has at most one burst in flight. A write can run at the same time as a read.

Back-pressure rules: a word leaves the inbound write stream only in a cycle where the memory also accepts it on the W channel, so the write stream is throttled by the W-channel ready. A read beat is taken from the R channel only in a cycle where the outbound stream consumer is ready, so the read data channel is throttled by the stream's ready. Neither stream is buffered inside the block. A non-OKAY response on either side sets a sticky error flag.

Top module: `burst_dma_master`

## Requirements
- R1: While and after synchronous active-high reset, both command readies are high, the AW, W and AR valids and the read stream valid are low, and the error flag is low.
- R2: A write command is accepted in a cycle where its valid and ready are both high. In the next cycle AWVALID rises and the write command ready falls. AWADDR equals the command address and AWLEN equals the command count (number of words minus one). AWSIZE is 3, AWBURST is 2'b01 (INCR) and WSTRB is 8'hFF. Address and length stay stable until AWREADY is sampled high.
- R3: After the AW handshake, WVALID follows the write stream valid and the write stream ready follows WREADY. WDATA is the stream word, so words reach memory in stream order.
- R4: WLAST is high only on the W beat whose zero-based index equals the command count. A count of 0 gives a single beat and a count of 255 gives 256 beats.
- R5: After the last W beat, BREADY is high until BVALID is sampled. The write command ready returns high in the cycle after that B handshake.
- R6: A read command drives ARVALID in the next cycle. ARADDR and ARLEN equal the command address and count, ARSIZE is 3 and ARBURST is 2'b01. These values are held until ARREADY is sampled high.
- R7: In the read data phase, RREADY follows the read stream ready and the read stream valid follows RVALID. Read stream data is RDATA in beat order.
- R8: The read command ready returns high in the cycle after the R beat carrying RLAST is transferred.
- R9: A BRESP or RRESP other than 2'b00 (OKAY), taken in a handshake, sets the error flag. The flag stays set until reset.
- R10: A write burst and a read burst can be outstanding at the same time, each progressing on its own channels.
- R11: A command valid raised while that direction's ready is low is ignored: it starts no address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wcmd_addr | input | 32 | Write byte start address |
| wcmd_len | input | 8 | Write word count minus one |
| wcmd_valid | input | 1 | Write command valid |
| wcmd_ready | output | 1 | Write command ready / write done |
| wstrm_data | input | 64 | Inbound write stream data |
| wstrm_valid | input | 1 | Inbound write stream valid |
| wstrm_ready | output | 1 | Inbound write stream ready |
| rcmd_addr | input | 32 | Read byte start address |
| rcmd_len | input | 8 | Read word count minus one |
| rcmd_valid | input | 1 | Read command valid |
| rcmd_ready | output | 1 | Read command ready / read done |
| rstrm_data | output | 64 | Outbound read stream data |
| rstrm_valid | output | 1 | Outbound read stream valid |
| rstrm_ready | input | 1 | Outbound read stream ready |
| bus_err | output | 1 | Sticky bus error flag |
| mem_awid | output | 1 | Write ID (0) |
| mem_awaddr | output | 32 | Write burst address |
| mem_awlen | output | 8 | Write burst length |
| mem_awsize | output | 3 | Write beat size |
| mem_awburst | output | 2 | Write burst type |
| mem_awlock | output | 1 | Lock (0) |
| mem_awcache | output | 4 | Cache attributes |
| mem_awprot | output | 3 | Protection (0) |
| mem_awqos | output | 4 | QoS (0) |
| mem_awregion | output | 4 | Region (0) |
| mem_awuser | output | 1 | User (0) |
| mem_awvalid | output | 1 | Write address valid |
| mem_awready | input | 1 | Write address ready |
| mem_wdata | output | 64 | Write data |
| mem_wstrb | output | 8 | Write strobes |
| mem_wlast | output | 1 | Last write beat |
| mem_wuser | output | 1 | User (0) |
| mem_wvalid | output | 1 | Write data valid |
| mem_wready | input | 1 | Write data ready |
| mem_bresp | input | 2 | Write response |
| mem_bvalid | input | 1 | Write response valid |
| mem_bready | output | 1 | Write response ready |
| mem_arid | output | 1 | Read ID (0) |
| mem_araddr | output | 32 | Read burst address |
| mem_arlen | output | 8 | Read burst length |
| mem_arsize | output | 3 | Read beat size |
| mem_arburst | output | 2 | Read burst type |
| mem_arlock | output | 1 | Lock (0) |
| mem_arcache | output | 4 | Cache attributes |
| mem_arprot | output | 3 | Protection (0) |
| mem_arqos | output | 4 | QoS (0) |
| mem_arregion | output | 4 | Region (0) |
| mem_aruser | output | 1 | User (0) |
| mem_arvalid | output | 1 | Read address valid |
| mem_arready | input | 1 | Read address ready |
| mem_rdata | input | 64 | Read data |
| mem_rresp | input | 2 | Read response |
| mem_rlast | input | 1 | Last read beat |
| mem_rvalid | input | 1 | Read data valid |
| mem_rready | output | 1 | Read data ready |

## Verification
The bench builds the block with its default parameters: 64-bit data, 8-bit count and 32-bit address. With these values both extremes of the count field can be reached, including a single-beat burst and a full 256-beat burst on each side. The slave and stream handshakes are randomly throttled, so address holds, stalled beats and delayed responses all occur. The count width also keeps the longest burst short enough to run several write-only, read-only and overlapping passes, plus error-response injection and a reset that clears the sticky flag.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  typedef enum logic [1:0] {WR_IDLE, WR_ADDR, WR_DATA, WR_RESP} wr_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_ADDR, RD_DATA} rd_state_e;
endpackage

// File: rtl/bdm_wr_engine.sv
module bdm_wr_engine
  import bdm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [LEN_W-1:0]  awlen,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              err
);
  wr_state_e         st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  beat_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= WR_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      beat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        WR_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          len_q  <= cmd_len;
          st     <= WR_ADDR;
        end
        WR_ADDR: if (awready) begin
          beat_q <= '0;
          st     <= WR_DATA;
        end
        WR_DATA: if (in_valid && wready) begin
          if (beat_q == len_q) st <= WR_RESP;
          else                 beat_q <= beat_q + 1'b1;
        end
        WR_RESP: if (bvalid) begin
          if (bresp != RESP_OKAY) err_q <= 1'b1;
          st <= WR_IDLE;
        end
      endcase
    end
  end

  assign cmd_ready = (st == WR_IDLE);
  assign awvalid   = (st == WR_ADDR);
  assign awaddr    = addr_q;
  assign awlen     = len_q;
  assign wvalid    = (st == WR_DATA) && in_valid;
  assign in_ready  = (st == WR_DATA) && wready;
  assign wdata     = in_data;
  assign wlast     = (st == WR_DATA) && (beat_q == len_q);
  assign bready    = (st == WR_RESP);
  assign err       = err_q;

  // R2
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
  // R2
  wcmd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_ready && awvalid);
  // R4
  wlast_end_chk: assert property (@(posedge clk) disable iff (rst)
    wvalid && wready && wlast |=> !wvalid && bready);
  // R5
  wdone_chk: assert property (@(posedge clk) disable iff (rst)
    bvalid && bready |=> cmd_ready && !bready);
endmodule

// File: rtl/bdm_rd_engine.sv
module bdm_rd_engine
  import bdm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] araddr,
  output logic [LEN_W-1:0]  arlen,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  input  logic              rvalid,
  output logic              rready,
  output logic              err
);
  rd_state_e         st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RD_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        RD_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          len_q  <= cmd_len;
          st     <= RD_ADDR;
        end
        RD_ADDR: if (arready) st <= RD_DATA;
        RD_DATA: if (rvalid && out_ready) begin
          if (rresp != RESP_OKAY) err_q <= 1'b1;
          if (rlast) st <= RD_IDLE;
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == RD_IDLE);
  assign arvalid   = (st == RD_ADDR);
  assign araddr    = addr_q;
  assign arlen     = len_q;
  assign rready    = (st == RD_DATA) && out_ready;
  assign out_valid = (st == RD_DATA) && rvalid;
  assign out_data  = rdata;
  assign err       = err_q;

  // R6
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));
  // R8
  rdone_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid && rready && rlast |=> cmd_ready && !rready);
  // R7
  rstall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !rready);
endmodule

// File: rtl/burst_dma_master.sv
module burst_dma_master
  import bdm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wcmd_addr,
  input  logic [LEN_W-1:0]  wcmd_len,
  input  logic              wcmd_valid,
  output logic              wcmd_ready,
  input  logic [DATA_W-1:0] wstrm_data,
  input  logic              wstrm_valid,
  output logic              wstrm_ready,
  input  logic [ADDR_W-1:0] rcmd_addr,
  input  logic [LEN_W-1:0]  rcmd_len,
  input  logic              rcmd_valid,
  output logic              rcmd_ready,
  output logic [DATA_W-1:0] rstrm_data,
  output logic              rstrm_valid,
  input  logic              rstrm_ready,
  output logic              bus_err,
  output logic              mem_awid,
  output logic [ADDR_W-1:0] mem_awaddr,
  output logic [LEN_W-1:0]  mem_awlen,
  output logic [2:0]        mem_awsize,
  output logic [1:0]        mem_awburst,
  output logic              mem_awlock,
  output logic [3:0]        mem_awcache,
  output logic [2:0]        mem_awprot,
  output logic [3:0]        mem_awqos,
  output logic [3:0]        mem_awregion,
  output logic              mem_awuser,
  output logic              mem_awvalid,
  input  logic              mem_awready,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_wstrb,
  output logic              mem_wlast,
  output logic              mem_wuser,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  input  logic [1:0]        mem_bresp,
  input  logic              mem_bvalid,
  output logic              mem_bready,
  output logic              mem_arid,
  output logic [ADDR_W-1:0] mem_araddr,
  output logic [LEN_W-1:0]  mem_arlen,
  output logic [2:0]        mem_arsize,
  output logic [1:0]        mem_arburst,
  output logic              mem_arlock,
  output logic [3:0]        mem_arcache,
  output logic [2:0]        mem_arprot,
  output logic [3:0]        mem_arqos,
  output logic [3:0]        mem_arregion,
  output logic              mem_aruser,
  output logic              mem_arvalid,
  input  logic              mem_arready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [1:0]        mem_rresp,
  input  logic              mem_rlast,
  input  logic              mem_rvalid,
  output logic              mem_rready
);
  localparam int         STRB_W    = DATA_W / 8;
  localparam logic [2:0] BEAT_SIZE = 3'($clog2(STRB_W));
  localparam logic [3:0] CACHE_ATTR = 4'b0011;

  logic wr_err, rd_err;

  bdm_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst(rst),
    .cmd_addr(wcmd_addr), .cmd_len(wcmd_len), .cmd_valid(wcmd_valid), .cmd_ready(wcmd_ready),
    .in_data(wstrm_data), .in_valid(wstrm_valid), .in_ready(wstrm_ready),
    .awaddr(mem_awaddr), .awlen(mem_awlen), .awvalid(mem_awvalid), .awready(mem_awready),
    .wdata(mem_wdata), .wlast(mem_wlast), .wvalid(mem_wvalid), .wready(mem_wready),
    .bresp(mem_bresp), .bvalid(mem_bvalid), .bready(mem_bready), .err(wr_err)
  );

  bdm_rd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst(rst),
    .cmd_addr(rcmd_addr), .cmd_len(rcmd_len), .cmd_valid(rcmd_valid), .cmd_ready(rcmd_ready),
    .out_data(rstrm_data), .out_valid(rstrm_valid), .out_ready(rstrm_ready),
    .araddr(mem_araddr), .arlen(mem_arlen), .arvalid(mem_arvalid), .arready(mem_arready),
    .rdata(mem_rdata), .rresp(mem_rresp), .rlast(mem_rlast), .rvalid(mem_rvalid),
    .rready(mem_rready), .err(rd_err)
  );

  assign mem_awid     = 1'b0;
  assign mem_awsize   = BEAT_SIZE;
  assign mem_awburst  = BURST_INCR;
  assign mem_awlock   = 1'b0;
  assign mem_awcache  = CACHE_ATTR;
  assign mem_awprot   = 3'd0;
  assign mem_awqos    = 4'd0;
  assign mem_awregion = 4'd0;
  assign mem_awuser   = 1'b0;
  assign mem_wstrb    = '1;
  assign mem_wuser    = 1'b0;
  assign mem_arid     = 1'b0;
  assign mem_arsize   = BEAT_SIZE;
  assign mem_arburst  = BURST_INCR;
  assign mem_arlock   = 1'b0;
  assign mem_arcache  = CACHE_ATTR;
  assign mem_arprot   = 3'd0;
  assign mem_arqos    = 4'd0;
  assign mem_arregion = 4'd0;
  assign mem_aruser   = 1'b0;

  assign bus_err = wr_err | rd_err;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> bus_err);
endmodule

// File: tb/burst_dma_master_test.sv
module burst_dma_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] wcmd_addr = '0, rcmd_addr = '0;
  logic [7:0]  wcmd_len = '0, rcmd_len = '0;
  logic        wcmd_valid = 1'b0, rcmd_valid = 1'b0;
  logic [63:0] wstrm_data = '0, mem_rdata = '0;
  logic        wstrm_valid = 1'b0, rstrm_ready = 1'b0;
  logic        mem_awready = 1'b0, mem_wready = 1'b0, mem_bvalid = 1'b0;
  logic        mem_arready = 1'b0, mem_rvalid = 1'b0, mem_rlast = 1'b0;
  logic [1:0]  mem_bresp = '0, mem_rresp = '0;

  logic        wcmd_ready, wstrm_ready, rcmd_ready, rstrm_valid, bus_err;
  logic [63:0] rstrm_data, mem_wdata;
  logic        mem_awid, mem_awlock, mem_awuser, mem_awvalid, mem_wlast, mem_wuser, mem_wvalid, mem_bready;
  logic        mem_arid, mem_arlock, mem_aruser, mem_arvalid, mem_rready;
  logic [31:0] mem_awaddr, mem_araddr;
  logic [7:0]  mem_awlen, mem_arlen, mem_wstrb;
  logic [2:0]  mem_awsize, mem_awprot, mem_arsize, mem_arprot;
  logic [1:0]  mem_awburst, mem_arburst;
  logic [3:0]  mem_awcache, mem_awqos, mem_awregion, mem_arcache, mem_arqos, mem_arregion;

  burst_dma_master uut (.*);

  int vectors = 0, fails = 0;
  // reference model state
  int wph = 0, rph = 0, wbeat = 0, wlen = 0, rlen = 0, rbeat = 0;
  logic [31:0] waddr_m = '0, raddr_m = '0;
  bit err_m = 0, wr_bad = 0, rd_bad = 0;
  int aw_hs = 0;

  task automatic chk(input bit ok, input string req, input string nm,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_awvalid && mem_awready) aw_hs++;
    if (rst) begin
      wph = 0; rph = 0; err_m = 0;
    end else begin
      case (wph)
        0: if (wcmd_valid) begin wph = 1; waddr_m = wcmd_addr; wlen = wcmd_len; end
        1: if (mem_awready) begin wph = 2; wbeat = 0; end
        2: if (wstrm_valid && mem_wready) begin
             if (wbeat == wlen) wph = 3; else wbeat++;
           end
        default: if (mem_bvalid) begin wph = 0; if (mem_bresp != 0) err_m = 1; end
      endcase
      case (rph)
        0: if (rcmd_valid) begin rph = 1; raddr_m = rcmd_addr; rlen = rcmd_len; end
        1: if (mem_arready) begin rph = 2; rbeat = 0; end
        default: if (mem_rvalid && rstrm_ready) begin
             if (mem_rresp != 0) err_m = 1;
             if (rbeat == rlen) rph = 0; else rbeat++;
           end
      endcase
    end
  end

  task automatic drive();
    mem_awready = ($urandom % 3) != 0;
    mem_wready  = ($urandom % 4) != 0;
    mem_arready = ($urandom % 3) != 0;
    wstrm_valid = ($urandom % 4) != 0;
    wstrm_data  = {$urandom, $urandom};
    rstrm_ready = ($urandom % 4) != 0;
    mem_bvalid  = (wph == 3) && (($urandom % 2) != 0);
    mem_bresp   = wr_bad ? 2'b10 : 2'b00;
    mem_rvalid  = (rph == 2) && (($urandom % 4) != 0);
    mem_rdata   = {raddr_m, 24'h0, 8'(rbeat)} ^ {$urandom, 32'h0};
    mem_rlast   = (rph == 2) && (rbeat == rlen);
    mem_rresp   = rd_bad ? 2'b10 : 2'b00;
  endtask

  task automatic compare();
    chk(wcmd_ready == (wph == 0), "R5", "wcmd_ready", 64'(wcmd_ready), 64'(wph == 0));
    chk(mem_awvalid == (wph == 1), "R2", "awvalid", 64'(mem_awvalid), 64'(wph == 1));
    if (wph == 1) begin
      chk(mem_awaddr == waddr_m, "R2", "awaddr", 64'(mem_awaddr), 64'(waddr_m));
      chk(mem_awlen == 8'(wlen), "R2", "awlen", 64'(mem_awlen), 64'(wlen));
      chk(mem_awsize == 3'd3 && mem_awburst == 2'b01 && mem_wstrb == 8'hFF, "R2", "awsize/burst/strb",
          64'({mem_awsize, mem_awburst, mem_wstrb}), 64'({3'd3, 2'b01, 8'hFF}));
    end
    chk(mem_wvalid == (wph == 2 && wstrm_valid), "R3", "wvalid", 64'(mem_wvalid), 64'(wph == 2 && wstrm_valid));
    chk(wstrm_ready == (wph == 2 && mem_wready), "R3", "wstrm_ready", 64'(wstrm_ready), 64'(wph == 2 && mem_wready));
    if (mem_wvalid) begin
      chk(mem_wdata == wstrm_data, "R3", "wdata", mem_wdata, wstrm_data);
      chk(mem_wlast == (wbeat == wlen), "R4", "wlast", 64'(mem_wlast), 64'(wbeat == wlen));
    end
    chk(mem_bready == (wph == 3), "R5", "bready", 64'(mem_bready), 64'(wph == 3));
    chk(rcmd_ready == (rph == 0), "R8", "rcmd_ready", 64'(rcmd_ready), 64'(rph == 0));
    chk(mem_arvalid == (rph == 1), "R6", "arvalid", 64'(mem_arvalid), 64'(rph == 1));
    if (rph == 1) begin
      chk(mem_araddr == raddr_m, "R6", "araddr", 64'(mem_araddr), 64'(raddr_m));
      chk(mem_arlen == 8'(rlen), "R6", "arlen", 64'(mem_arlen), 64'(rlen));
      chk(mem_arsize == 3'd3 && mem_arburst == 2'b01, "R6", "arsize/burst",
          64'({mem_arsize, mem_arburst}), 64'({3'd3, 2'b01}));
    end
    chk(mem_rready == (rph == 2 && rstrm_ready), "R7", "rready", 64'(mem_rready), 64'(rph == 2 && rstrm_ready));
    chk(rstrm_valid == (rph == 2 && mem_rvalid), "R7", "rstrm_valid", 64'(rstrm_valid), 64'(rph == 2 && mem_rvalid));
    if (rstrm_valid) chk(rstrm_data == mem_rdata, "R7", "rstrm_data", rstrm_data, mem_rdata);
    chk(bus_err == err_m, "R9", "bus_err", 64'(bus_err), 64'(err_m));
  endtask

  task automatic cyc();
    @(negedge clk);
    drive();
    #1 compare();
  endtask

  task automatic issue_wr(input logic [31:0] a, input logic [7:0] n);
    while (wph != 0) cyc();
    wcmd_addr = a; wcmd_len = n; wcmd_valid = 1'b1;
    cyc();
    wcmd_valid = 1'b0;
  endtask

  task automatic issue_rd(input logic [31:0] a, input logic [7:0] n);
    while (rph != 0) cyc();
    rcmd_addr = a; rcmd_len = n; rcmd_valid = 1'b1;
    cyc();
    rcmd_valid = 1'b0;
  endtask

  task automatic settle();
    while (wph != 0 || rph != 0) cyc();
    cyc();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    // R1: reset state seen at the ports
    chk(wcmd_ready && rcmd_ready, "R1", "cmd readies", 64'({wcmd_ready, rcmd_ready}), 64'h3);
    chk(!mem_awvalid && !mem_wvalid && !mem_arvalid && !rstrm_valid, "R1", "valids",
        64'({mem_awvalid, mem_wvalid, mem_arvalid, rstrm_valid}), 64'h0);
    chk(!bus_err, "R1", "bus_err", 64'(bus_err), 64'h0);
  endtask

  initial begin
    int aw_before;
    bit both_busy;
    do_reset();
    // R2 R3 R4 R5: write lengths 0, 3, 255
    issue_wr(32'h0000_1000, 8'd0);   settle();
    issue_wr(32'h0000_2040, 8'd3);   settle();
    issue_wr(32'h0000_3000, 8'd255); settle();
    // R6 R7 R8: read lengths 0, 5, 255
    issue_rd(32'h0000_4000, 8'd0);   settle();
    issue_rd(32'h0000_5080, 8'd5);   settle();
    issue_rd(32'h0000_6000, 8'd255); settle();
    // R10: overlapping write and read
    issue_wr(32'h0000_7000, 8'd40);
    issue_rd(32'h0000_8000, 8'd40);
    both_busy = 0;
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (!wcmd_ready && !rcmd_ready) both_busy = 1;
    end
    chk(both_busy, "R10", "both busy", 64'(both_busy), 64'h1);
    settle();
    // R11: valid while busy is ignored
    aw_before = aw_hs;
    issue_wr(32'h0000_9000, 8'd255);
    wcmd_addr = 32'hDEAD_0000; wcmd_valid = 1'b1;
    repeat (5) cyc();
    wcmd_valid = 1'b0;
    settle();
    chk(aw_hs - aw_before == 1, "R11", "aw handshakes", 64'(aw_hs - aw_before), 64'h1);
    // R9: error responses, sticky until reset
    wr_bad = 1; issue_wr(32'h0000_A000, 8'd2); settle(); wr_bad = 0;
    chk(bus_err, "R9", "write error flag", 64'(bus_err), 64'h1);
    issue_rd(32'h0000_B000, 8'd2); settle();
    chk(bus_err, "R9", "flag sticky", 64'(bus_err), 64'h1);
    do_reset();
    rd_bad = 1; issue_rd(32'h0000_C000, 8'd1); settle(); rd_bad = 0;
    chk(bus_err, "R9", "read error flag", 64'(bus_err), 64'h1);
    do_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5/R8 watchdog actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule